// File: doc/BRIEF.md
# Machine-Cycle Timing Sequencer

This block produces the bus timing for a small 8-bit processor core. A decoder upstream reduces each opcode to an instruction-class code. When `start_i` is pulsed while the sequencer is idle, it latches that code and walks through the machine cycles of the class, one T state per clock. On every clock it reports the kind of machine cycle in progress, the ordinal of that cycle within the instruction, the current T-state number, the read and write strobes, a wait indicator and a one-clock completion pulse.

Slow memory or I/O stretches any bus cycle by holding `ready_i` low. The sequencer samples it at the end of T2 and then on every wait state. Until `ready_i` returns high it keeps the T-state number frozen at 2. The datapath, the opcode-to-class decode and the bus contents are not part of this block.

Top module: `mcyc_seq`

## Requirements
- R1: While `rst_ni` is low and after its release with no start, the block is idle: `busy_o`, `rd_o`, `wr_o`, `wait_o` and `done_o` are 0, and `mcyc_o`, `mcyc_idx_o` and `tstate_o` are 0.
- R2: `start_i` high at a clock edge while idle latches `class_i`. From the next clock `mcyc_o` shows an opcode fetch (code 1) with `tstate_o`=1 and `mcyc_idx_o`=1. `tstate_o` then rises by one per clock outside wait states, and `mcyc_idx_o` counts machine cycles from 1.
- R3: Cycle-type codes are 0 idle, 1 opcode fetch, 2 memory read, 3 memory write, 4 I/O read and 5 I/O write. By class code the sequences are:
  - 0 register move: fetch
  - 1 16-bit increment: fetch
  - 2 immediate 16-bit load: fetch, read, read
  - 3 direct store: fetch, read, read, write
  - 4 direct load: fetch, read, read, read
  - 5 return: fetch, read, read
  - 6 call: fetch, read, read, write, write
  - 7 port input: fetch, read, I/O read
  - 8 port output: fetch, read, I/O write
- R4: An opcode fetch lasts 6 T states for classes 1 and 6 and 4 T states for every other class. All other machine cycles last 3 T states, not counting waits.
- R5: With `ready_i` held high, the T states from the first fetch state to the done state total 4, 6, 10, 13, 13, 10, 18, 10 and 10 for classes 0 to 8.
- R6: `ready_i` is sampled at the edge that ends T2 of every machine cycle and at each wait state. While it is low the next state is a wait state, with `wait_o`=1 and `tstate_o` held at 2. The first edge with `ready_i` high moves on to T3 with `wait_o`=0.
- R7: `rd_o` is high during T2, wait states and T3 of fetch, memory-read and I/O-read cycles. `wr_o` is high during the same states of memory-write and I/O-write cycles. Both are low otherwise.
- R8: `done_o` is high for exactly one clock, on the last T state of the last machine cycle. The next clock is idle.
- R9: `start_i` and `class_i` are ignored while `busy_o` is high, so the running sequence continues unchanged.
- R10: Class codes 9 to 15 run as a single 4-T-state opcode fetch.
- R11: `busy_o` is high from the first fetch T state through the done clock, inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an instruction (taken only when idle) |
| class_i | input | 4 | Instruction-class code |
| ready_i | input | 1 | Bus ready; low inserts wait states after T2 |
| busy_o | output | 1 | Instruction in progress |
| mcyc_o | output | 3 | Current machine-cycle type code |
| mcyc_idx_o | output | 3 | Machine-cycle ordinal, 1-based, 0 when idle |
| tstate_o | output | 3 | T-state number, 0 when idle |
| wait_o | output | 1 | Current state is a wait state |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| done_o | output | 1 | Final T state of the instruction |

## Verification
The hardest case to reach is a wait train that starts at the very T2 where the cycle type is about to change. Examples are the T2 of a 6-state fetch, where the strobe must stay up through the wait, and the last write of a call, where the done pulse must slip by the number of waits.

The bench drives `ready_i` from a pseudo-random source in several runs over all classes. It also runs one pass with long low stretches that begin exactly when `tstate_o` reads 2, so every cycle type goes through entry to and exit from waits. A reference model built from per-class lists of cycle types and lengths is compared against every output on every clock, including the stretch where `start_i` is held high during a call.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  localparam int MAX_CYC = 5;
  localparam int CLS_W   = 4;
  localparam int TS_W    = 3;
  localparam int TY_W    = 3;
  localparam int IDX_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [TY_W-1:0] {
    CYC_IDLE  = 3'd0,
    CYC_FETCH = 3'd1,
    CYC_MRD   = 3'd2,
    CYC_MWR   = 3'd3,
    CYC_IORD  = 3'd4,
    CYC_IOWR  = 3'd5
  } cyc_e;

  localparam logic [CLS_W-1:0] CLS_MOVE  = 4'd0;
  localparam logic [CLS_W-1:0] CLS_INC16 = 4'd1;
  localparam logic [CLS_W-1:0] CLS_LDI16 = 4'd2;
  localparam logic [CLS_W-1:0] CLS_STD   = 4'd3;
  localparam logic [CLS_W-1:0] CLS_LDD   = 4'd4;
  localparam logic [CLS_W-1:0] CLS_RET   = 4'd5;
  localparam logic [CLS_W-1:0] CLS_CALL  = 4'd6;
  localparam logic [CLS_W-1:0] CLS_PIN   = 4'd7;
  localparam logic [CLS_W-1:0] CLS_POUT  = 4'd8;

  typedef struct packed {
    logic [IDX_W-1:0]                n_cyc;
    logic                            long_fetch;
    logic [MAX_CYC-1:0][TY_W-1:0]    seq;
  } prog_t;
endpackage

// File: rtl/mcyc_decode.sv
module mcyc_decode
  import mcyc_pkg::*;
(
  input  logic [CLS_W-1:0] cls_i,
  output prog_t            prog_o
);
  always_comb begin
    prog_o            = '0;
    prog_o.n_cyc      = IDX_W'(1);
    prog_o.long_fetch = 1'b0;
    prog_o.seq[0]     = CYC_FETCH;
    unique case (cls_i)
      CLS_INC16: prog_o.long_fetch = 1'b1;
      CLS_LDI16, CLS_RET: begin
        prog_o.n_cyc  = IDX_W'(3);
        prog_o.seq[1] = CYC_MRD;
        prog_o.seq[2] = CYC_MRD;
      end
      CLS_STD, CLS_LDD: begin
        prog_o.n_cyc  = IDX_W'(4);
        prog_o.seq[1] = CYC_MRD;
        prog_o.seq[2] = CYC_MRD;
        prog_o.seq[3] = (cls_i == CLS_STD) ? CYC_MWR : CYC_MRD;
      end
      CLS_CALL: begin
        prog_o.n_cyc      = IDX_W'(5);
        prog_o.long_fetch = 1'b1;
        prog_o.seq[1]     = CYC_MRD;
        prog_o.seq[2]     = CYC_MRD;
        prog_o.seq[3]     = CYC_MWR;
        prog_o.seq[4]     = CYC_MWR;
      end
      CLS_PIN, CLS_POUT: begin
        prog_o.n_cyc  = IDX_W'(3);
        prog_o.seq[1] = CYC_MRD;
        prog_o.seq[2] = (cls_i == CLS_PIN) ? CYC_IORD : CYC_IOWR;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mcyc_tcnt.sv
module mcyc_tcnt
  import mcyc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            run_i,
  input  logic            ready_i,
  input  logic            last_i,
  input  logic [TS_W-1:0] len_i,
  output logic [TS_W-1:0] t_o,
  output logic            wait_o,
  output logic            end_o
);
  localparam logic [TS_W-1:0] T_ONE = TS_W'(1);
  localparam logic [TS_W-1:0] T_TWO = TS_W'(2);

  logic [TS_W-1:0] t_q;
  logic            w_q;

  assign end_o  = run_i && (t_q == len_i) && !w_q;
  assign t_o    = t_q;
  assign wait_o = w_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q <= '0;
      w_q <= 1'b0;
    end else if (load_i) begin
      t_q <= T_ONE;
      w_q <= 1'b0;
    end else if (run_i) begin
      if (t_q == T_TWO) begin
        // hold at T2 until the bus reports ready
        if (!ready_i) begin
          w_q <= 1'b1;
        end else begin
          w_q <= 1'b0;
          t_q <= t_q + T_ONE;
        end
      end else if (t_q == len_i) begin
        t_q <= last_i ? '0 : T_ONE;
      end else begin
        t_q <= t_q + T_ONE;
      end
    end
  end
endmodule

// File: rtl/mcyc_strobe.sv
module mcyc_strobe
  import mcyc_pkg::*;
(
  input  logic            busy_i,
  input  cyc_e            ty_i,
  input  logic [TS_W-1:0] t_i,
  output logic            rd_o,
  output logic            wr_o
);
  logic bus_phase;
  logic is_rd;
  logic is_wr;

  assign bus_phase = busy_i && (t_i == TS_W'(2) || t_i == TS_W'(3));
  assign is_rd     = (ty_i == CYC_FETCH) || (ty_i == CYC_MRD) || (ty_i == CYC_IORD);
  assign is_wr     = (ty_i == CYC_MWR) || (ty_i == CYC_IOWR);
  assign rd_o      = bus_phase && is_rd;
  assign wr_o      = bus_phase && is_wr;
endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
  import mcyc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CLS_W-1:0] class_i,
  input  logic             ready_i,
  output logic             busy_o,
  output logic [TY_W-1:0]  mcyc_o,
  output logic [IDX_W-1:0] mcyc_idx_o,
  output logic [TS_W-1:0]  tstate_o,
  output logic             wait_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             done_o
);
  logic             busy_q;
  logic [CLS_W-1:0] cls_q;
  logic [IDX_W-1:0] idx_q;
  prog_t            prog;
  cyc_e             cur_ty;
  logic [TS_W-1:0]  cur_len;
  logic             last_cyc;
  logic             accept;
  logic             cyc_end;
  logic [TS_W-1:0]  t_cur;

  assign accept   = start_i && !busy_q;
  assign cur_ty   = cyc_e'(prog.seq[idx_q]);
  assign cur_len  = (cur_ty == CYC_FETCH) ? (prog.long_fetch ? TS_W'(6) : TS_W'(4)) : TS_W'(3);
  assign last_cyc = (idx_q == prog.n_cyc - IDX_W'(1));

  mcyc_decode u_dec (
    .cls_i  (cls_q),
    .prog_o (prog)
  );

  mcyc_tcnt u_tcnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .run_i   (busy_q),
    .ready_i (ready_i),
    .last_i  (last_cyc),
    .len_i   (cur_len),
    .t_o     (t_cur),
    .wait_o  (wait_o),
    .end_o   (cyc_end)
  );

  mcyc_strobe u_strb (
    .busy_i (busy_q),
    .ty_i   (cur_ty),
    .t_i    (t_cur),
    .rd_o   (rd_o),
    .wr_o   (wr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cls_q  <= '0;
      idx_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cls_q  <= class_i;
      idx_q  <= '0;
    end else if (cyc_end) begin
      if (last_cyc) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q  <= idx_q + IDX_W'(1);
      end
    end
  end

  assign busy_o     = busy_q;
  assign mcyc_o     = busy_q ? TY_W'(cur_ty) : TY_W'(CYC_IDLE);
  assign mcyc_idx_o = busy_q ? idx_q + IDX_W'(1) : '0;
  assign tstate_o   = t_cur;
  assign done_o     = cyc_end && last_cyc;
endmodule

// File: rtl/mcyc_seq_chk.sv
module mcyc_seq_chk
  import mcyc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ready_i,
  input logic             busy_o,
  input logic [TY_W-1:0]  mcyc_o,
  input logic [IDX_W-1:0] mcyc_idx_o,
  input logic [TS_W-1:0]  tstate_o,
  input logic             wait_o,
  input logic             rd_o,
  input logic             wr_o,
  input logic             done_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (mcyc_o == 0 && tstate_o == 0 && mcyc_idx_o == 0 && !rd_o && !wr_o && !wait_o && !done_o));

  assert_fetch_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (mcyc_o == TY_W'(CYC_FETCH) && tstate_o == 1 && mcyc_idx_o == 1));

  assert_len_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mcyc_o != TY_W'(CYC_FETCH)) |-> (tstate_o >= 1 && tstate_o <= 3));

  assert_wait_at_t2_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> (busy_o && tstate_o == 2));

  assert_wait_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tstate_o == 2 && !ready_i) |=> (wait_o && tstate_o == 2 && $stable(mcyc_o)));

  assert_wait_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && ready_i) |=> (!wait_o && tstate_o == 3));

  assert_strobe_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  assert_busy_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

bind mcyc_seq mcyc_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ready_i    (ready_i),
  .busy_o     (busy_o),
  .mcyc_o     (mcyc_o),
  .mcyc_idx_o (mcyc_idx_o),
  .tstate_o   (tstate_o),
  .wait_o     (wait_o),
  .rd_o       (rd_o),
  .wr_o       (wr_o),
  .done_o     (done_o)
);

// File: tb/mcyc_seq_tb_top.sv
module mcyc_seq_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] class_i = 4'd0;
  logic       ready_i = 1'b1;
  logic       busy_o, wait_o, rd_o, wr_o, done_o;
  logic [2:0] mcyc_o, mcyc_idx_o, tstate_o;

  int n_cmp = 0;
  int n_bad = 0;
  int busy_cnt = 0;
  int rdy_mode = 0;   // 0 high, 1 random, 2 long stretch at T2
  int stretch = 0;

  always #4 clk_i = ~clk_i;

  mcyc_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .class_i(class_i),
    .ready_i(ready_i), .busy_o(busy_o), .mcyc_o(mcyc_o), .mcyc_idx_o(mcyc_idx_o),
    .tstate_o(tstate_o), .wait_o(wait_o), .rd_o(rd_o), .wr_o(wr_o), .done_o(done_o)
  );

  // reference model: per-class lists of cycle types and lengths
  int q_ty[$];
  int q_len[$];
  int m_busy = 0, m_k = 0, m_t = 0, m_wait = 0;

  function automatic void push_cyc(int ty, int len);
    q_ty.push_back(ty);
    q_len.push_back(len);
  endfunction

  function automatic void build(int cls);
    q_ty.delete();
    q_len.delete();
    push_cyc(1, (cls == 1 || cls == 6) ? 6 : 4);
    case (cls)
      2, 5: begin push_cyc(2, 3); push_cyc(2, 3); end
      3:    begin push_cyc(2, 3); push_cyc(2, 3); push_cyc(3, 3); end
      4:    begin push_cyc(2, 3); push_cyc(2, 3); push_cyc(2, 3); end
      6:    begin push_cyc(2, 3); push_cyc(2, 3); push_cyc(3, 3); push_cyc(3, 3); end
      7:    begin push_cyc(2, 3); push_cyc(4, 3); end
      8:    begin push_cyc(2, 3); push_cyc(5, 3); end
      default: ;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_busy = 0; m_k = 0; m_t = 0; m_wait = 0;
    end else if (!m_busy) begin
      if (start_i) begin
        build(int'(class_i));
        m_busy = 1; m_k = 0; m_t = 1; m_wait = 0;
      end
    end else if (m_t == 2) begin
      if (!ready_i) m_wait = 1;
      else begin m_wait = 0; m_t = 3; end
    end else if (m_t == q_len[m_k]) begin
      if (m_k == q_ty.size() - 1) begin m_busy = 0; m_k = 0; m_t = 0; end
      else begin m_k++; m_t = 1; end
    end else begin
      m_t++;
    end
    #2;
    begin
      int e_ty, e_rd, e_wr, e_done, ph;
      e_ty   = m_busy ? q_ty[m_k] : 0;
      ph     = m_busy && (m_t == 2 || m_t == 3);
      e_rd   = ph && (e_ty == 1 || e_ty == 2 || e_ty == 4);
      e_wr   = ph && (e_ty == 3 || e_ty == 5);
      e_done = m_busy && m_t == q_len[m_k] && m_k == q_ty.size() - 1;
      chk("R3 cycle type", int'(mcyc_o), e_ty);
      chk("R4 tstate", int'(tstate_o), m_t);
      chk("R2 cycle index", int'(mcyc_idx_o), m_busy ? m_k + 1 : 0);
      chk("R6 wait", int'(wait_o), m_wait);
      chk("R7 rd", int'(rd_o), e_rd);
      chk("R7 wr", int'(wr_o), e_wr);
      chk("R8 done", int'(done_o), e_done);
      chk("R11 busy", int'(busy_o), m_busy);
      if (busy_o) busy_cnt++;
    end
  end

  // ready stimulus
  always @(negedge clk_i) begin
    case (rdy_mode)
      0: ready_i <= 1'b1;
      1: ready_i <= ($urandom % 3) != 0;
      default: begin
        if (stretch > 0) begin
          stretch <= stretch - 1;
          ready_i <= (stretch == 1);
        end else if (busy_o && tstate_o == 3'd1) begin
          stretch <= 3 + int'(mcyc_idx_o);
          ready_i <= 1'b0;
        end else begin
          ready_i <= 1'b1;
        end
      end
    endcase
  end

  task automatic run(int cls, int exp_len, string req);
    @(negedge clk_i);
    busy_cnt = 0;
    start_i = 1'b1;
    class_i = 4'(cls);
    @(negedge clk_i);
    start_i = 1'b0;
    while (busy_o) @(negedge clk_i);
    if (exp_len > 0) chk(req, busy_cnt, exp_len);
  endtask

  initial begin
    #3000000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int tot[9] = '{4, 6, 10, 13, 13, 10, 18, 10, 10};
    repeat (3) @(negedge clk_i);
    // R1: idle state during and after reset
    chk("R1 busy in reset", int'(busy_o), 0);
    chk("R1 tstate in reset", int'(tstate_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 type after reset", int'(mcyc_o), 0);
    chk("R1 strobes after reset", int'(rd_o | wr_o | done_o | wait_o), 0);

    // R5: totals with ready high, every class
    for (int c = 0; c < 9; c++) run(c, tot[c], "R5 total T states");
    // R10: undefined codes act as a single short fetch
    for (int c = 9; c < 16; c++) run(c, 4, "R10 undefined class length");

    // R9: start held high with a different class during a call
    @(negedge clk_i);
    busy_cnt = 0;
    start_i = 1'b1; class_i = 4'd6;
    @(negedge clk_i);
    class_i = 4'd0;
    repeat (5) @(negedge clk_i);
    start_i = 1'b0;
    while (busy_o) @(negedge clk_i);
    chk("R9 start ignored while busy", busy_cnt, 18);

    // R6: random ready, all classes
    rdy_mode = 1;
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 9; c++) run(c, 0, "R6");
    // R6: long wait stretches starting at T2
    rdy_mode = 2;
    for (int c = 0; c < 9; c++) run(c, 0, "R6");
    rdy_mode = 0;
    @(negedge clk_i);
    run(6, 18, "R5 call after waits");

    // R1: reset mid-instruction returns to idle
    @(negedge clk_i);
    start_i = 1'b1; class_i = 4'd3;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 busy after mid reset", int'(busy_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule